// File: doc/BRIEF.md
# Single-Channel Block-Move DMA Engine

This engine moves a block of data units on behalf of a CPU so that the processor stays free while the move runs. Software loads a small register file: a primary memory pointer, a secondary pointer, a unit count and a control word. Writing the control word with its start bit set launches the move. The engine then asks for the system bus on a request/grant pair and produces memory addresses and read or write strobes only while it holds the grant. It raises a maskable completion interrupt once the last unit has moved.

Three directions are supported. Peripheral-to-memory and memory-to-peripheral units each wait for the peripheral's ready strobe. Memory-to-memory units are a read at the primary pointer followed by a write at the secondary pointer, with the data held in between. A control bit sets the bus-ownership policy. In block mode the bus is held from the first unit through the last. In cycle-steal mode the bus is handed back after every unit and requested again for the next one.

Top module: `dma_engine`

## Requirements
- R1: After reset every register reads 0, `bus_req` is 0 and `irq` is 0.
- R2: `mem_rd` or `mem_wr` is only asserted while both `bus_req` and `bus_grant` are high. After a start, `bus_req` stays high until the grant arrives.
- R3: With direction code 0 (peripheral to memory), each unit waits for `per_ready`. In the cycle where `per_ready` is seen, `per_rdata` is written to memory at the primary pointer and `per_ack` pulses.
- R4: With direction code 1 (memory to peripheral), each unit waits for `per_ready`. Memory is read at the primary pointer and the read data is presented on `per_wdata` while `per_ack` is high.
- R5: With direction code 2 or 3 (memory to memory), each unit reads the primary pointer in one cycle. In the next cycle it writes that same data at the secondary pointer.
- R6: After each unit, the pointers used advance by 2^size bytes, where size is control bits [5:4]. The secondary pointer moves only in memory-to-memory mode. Both pointers read back at registers 0 and 1.
- R7: Register 2 reads the number of units still to move. It drops by one per unit and is 0 at completion.
- R8: With control bit 1 clear (block mode), a whole block is moved within a single rising edge of `bus_req`.
- R9: With control bit 1 set (cycle-steal mode), `bus_req` falls for at least one cycle after every unit except the last, so a block of N units makes N rising edges of `bus_req`.
- R10: Completion sets the done flag, which is bit 1 of register 4. Writing 1 to that bit clears the flag. `irq` equals the done flag ANDed with control bit 6. `busy` is bit 0 of register 4, and it is 0 once done is set.
- R11: While busy, writes to registers 0 to 3, including a write with the start bit (control bit 0) set, change nothing.
- R12: A start with a count of 0 sets the done flag on the next cycle and never asserts `bus_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_addr | input | 3 | Register select: 0 primary pointer, 1 secondary pointer, 2 count, 3 control, 4 status |
| reg_wdata | input | DW | CPU write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant from the CPU |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Unit size code (log2 of bytes) |
| mem_rd | output | 1 | Memory read strobe, data returned in the same cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| per_ready | input | 1 | Peripheral has data / can take data |
| per_rdata | input | DW | Data from the peripheral |
| per_wdata | output | DW | Data to the peripheral |
| per_ack | output | 1 | One unit exchanged with the peripheral |

## Verification
Some properties are checked on every cycle. Strobes may only appear under grant. An acknowledge may only come with a ready. The bus must be held or dropped after each unit according to the ownership policy. The count must drop by exactly one per unit. Configuration writes made while busy must leave the configuration unchanged. A zero-count start must never request the bus. Other behaviour only shows up in the bench's sweep over direction, policy, unit size and block length: the data that lands in memory or reaches the peripheral, the final pointer values, the number of bus requests per block, and the interrupt masking and clearing.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_UNIT,
    S_WR2,
    S_GAP
  } dma_state_e;

  // control word bits [6:1], in packed order
  typedef struct packed {
    logic       irq_en;
    logic [1:0] size;
    logic [1:0] dir;
    logic       steal;
  } dma_cfg_t;

  localparam logic [2:0] REG_PTR_A  = 3'd0;
  localparam logic [2:0] REG_PTR_B  = 3'd1;
  localparam logic [2:0] REG_COUNT  = 3'd2;
  localparam logic [2:0] REG_CTRL   = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;

  function automatic int unit_step(input logic [1:0] size);
    return 1 << size;
  endfunction

  function automatic logic is_m2m(input dma_cfg_t c);
    return c.dir[1];
  endfunction

  function automatic logic is_m2p(input dma_cfg_t c);
    return !c.dir[1] && c.dir[0];
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  logic [5:0] cfg_wdata,
  input  logic     done_set,
  input  logic     done_clr,
  output dma_cfg_t cfg,
  output logic     done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      done <= 1'b0;
    end else begin
      if (cfg_we)
        cfg <= dma_cfg_t'(cfg_wdata);
      if (done_set)
        done <= 1'b1;
      else if (done_clr)
        done <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_counters.sv
module dma_counters #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_cnt,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_count,
  input  logic          unit_done,
  input  logic          adv_b,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero,
  output logic          cnt_last
);
  import dma_pkg::*;

  localparam int NPTR = 2;

  logic [AW-1:0] step;
  logic [AW-1:0] ptr [NPTR];
  logic [NPTR-1:0] ld_v;
  logic [NPTR-1:0] adv_v;

  assign step  = AW'(unit_step(size));
  assign ld_v  = {ld_b, ld_a};
  assign adv_v = {adv_b && unit_done, unit_done};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr[g] <= '0;
      else if (ld_v[g])
        ptr[g] <= ld_addr;
      else if (adv_v[g])
        ptr[g] <= ptr[g] + step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (ld_cnt)
      cnt <= ld_count;
    else if (unit_done)
      cnt <= cnt - CW'(1);
  end

  assign addr_a   = ptr[0];
  assign addr_b   = ptr[1];
  assign cnt_zero = (cnt == '0);
  assign cnt_last = (cnt == CW'(1));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     cnt_zero,
  input  logic     cnt_last,
  input  logic     bus_grant,
  input  logic     per_ready,
  input  dma_cfg_t cfg,
  output logic     busy,
  output logic     bus_req,
  output logic     mem_rd,
  output logic     mem_wr,
  output logic     use_b,
  output logic     hold_en,
  output logic     per_ack,
  output logic     unit_done,
  output logic     done_set
);

  dma_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= S_IDLE;
    else
      state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    use_b     = 1'b0;
    hold_en   = 1'b0;
    per_ack   = 1'b0;
    unit_done = 1'b0;
    done_set  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start && cnt_zero)
          done_set = 1'b1;
        else if (start)
          state_d = S_REQ;
      end
      S_REQ: begin
        if (bus_grant)
          state_d = S_UNIT;
      end
      S_UNIT: begin
        if (is_m2m(cfg)) begin
          mem_rd  = 1'b1;
          hold_en = 1'b1;
          state_d = S_WR2;
        end else if (per_ready) begin
          per_ack   = 1'b1;
          mem_rd    = is_m2p(cfg);
          mem_wr    = !is_m2p(cfg);
          unit_done = 1'b1;
        end
      end
      S_WR2: begin
        mem_wr    = 1'b1;
        use_b     = 1'b1;
        unit_done = 1'b1;
      end
      S_GAP:   state_d = S_REQ;
      default: state_d = S_IDLE;
    endcase
    if (unit_done) begin
      if (cnt_last) begin
        state_d  = S_IDLE;
        done_set = 1'b1;
      end else if (cfg.steal) begin
        state_d = S_GAP;
      end else begin
        state_d = S_UNIT;
      end
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign bus_req = (state_q == S_REQ) || (state_q == S_UNIT) || (state_q == S_WR2);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          per_ready,
  input  logic [DW-1:0] per_rdata,
  output logic [DW-1:0] per_wdata,
  output logic          per_ack
);

  dma_cfg_t      cfg;
  logic          done, busy;
  logic [AW-1:0] addr_a, addr_b;
  logic [CW-1:0] cnt;
  logic          cnt_zero, cnt_last;
  logic          use_b, hold_en, unit_done, done_set;
  logic [DW-1:0] hold_q;

  // named decode events, also observed by the checker
  logic wr_idle, cfg_we, start_acc, cfg_wr_busy, done_clr;
  assign wr_idle     = reg_we && !busy;
  assign cfg_we      = wr_idle && (reg_addr == REG_CTRL);
  assign start_acc   = cfg_we && reg_wdata[0];
  assign cfg_wr_busy = reg_we && busy && (reg_addr == REG_CTRL);
  assign done_clr    = reg_we && (reg_addr == REG_STATUS) && reg_wdata[1];

  dma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (reg_wdata[6:1]),
    .done_set  (done_set),
    .done_clr  (done_clr),
    .cfg       (cfg),
    .done      (done)
  );

  dma_counters #(.AW(AW), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_a      (wr_idle && (reg_addr == REG_PTR_A)),
    .ld_b      (wr_idle && (reg_addr == REG_PTR_B)),
    .ld_cnt    (wr_idle && (reg_addr == REG_COUNT)),
    .ld_addr   (reg_wdata[AW-1:0]),
    .ld_count  (reg_wdata[CW-1:0]),
    .unit_done (unit_done),
    .adv_b     (is_m2m(cfg)),
    .size      (cfg.size),
    .addr_a    (addr_a),
    .addr_b    (addr_b),
    .cnt       (cnt),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .bus_grant (bus_grant),
    .per_ready (per_ready),
    .cfg       (cfg),
    .busy      (busy),
    .bus_req   (bus_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .use_b     (use_b),
    .hold_en   (hold_en),
    .per_ack   (per_ack),
    .unit_done (unit_done),
    .done_set  (done_set)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_q <= '0;
    else if (hold_en)
      hold_q <= mem_rdata;
  end

  assign mem_addr  = use_b ? addr_b : addr_a;
  assign mem_size  = cfg.size;
  assign mem_wdata = use_b ? hold_q : per_rdata;
  assign per_wdata = mem_rdata;
  assign irq       = done && cfg.irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_PTR_A:  reg_rdata = DW'(addr_a);
      REG_PTR_B:  reg_rdata = DW'(addr_b);
      REG_COUNT:  reg_rdata = DW'(cnt);
      REG_CTRL:   reg_rdata = DW'({cfg, 1'b0});
      REG_STATUS: reg_rdata = DW'({done, busy});
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk
  import dma_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          per_ack,
  input logic          per_ready,
  input logic          unit_done,
  input logic          cnt_last,
  input logic          cnt_zero,
  input logic [CW-1:0] cnt,
  input dma_cfg_t      cfg,
  input logic          start_acc,
  input logic          cfg_wr_busy,
  input logic          done_set,
  input logic          done,
  input logic          busy,
  input logic          irq
);

  AST_STROBE_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_grant)); // R2

  AST_ACK_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> per_ready); // R3

  AST_BLOCK_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cnt_last && !cfg.steal) |=> bus_req); // R8

  AST_STEAL_DROPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cnt_last && cfg.steal) |=> !bus_req); // R9

  AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (cnt == $past(cnt) - CW'(1))); // R7

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> (!busy && done)); // R10

  AST_BUSY_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_busy |=> $stable(cfg)); // R11

  AST_ZERO_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && cnt_zero) |=> (!bus_req && !busy && done)); // R12

endmodule

bind dma_engine dma_engine_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_grant   (bus_grant),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .per_ack     (per_ack),
  .per_ready   (per_ready),
  .unit_done   (unit_done),
  .cnt_last    (cnt_last),
  .cnt_zero    (cnt_zero),
  .cnt         (cnt),
  .cfg         (cfg),
  .start_acc   (start_acc),
  .cfg_wr_busy (cfg_wr_busy),
  .done_set    (done_set),
  .done        (done),
  .busy        (busy),
  .irq         (irq)
);

// File: tb/dma_engine_test.sv
`timescale 1ns/1ps
module dma_engine_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq, bus_req, mem_rd, mem_wr, per_ack, per_ready;
  logic          bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata, per_rdata, per_wdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_engine #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .per_ready(per_ready),
    .per_rdata(per_rdata), .per_wdata(per_wdata), .per_ack(per_ack)
  );

  // CPU side: grant follows request one cycle later
  always @(posedge clk) bus_grant <= rst_n ? bus_req : 1'b0;

  // memory model: same-cycle read, write on the edge
  logic [DW-1:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  // peripheral model
  int cyc = 0;
  int per_cnt = 0;
  logic rdy_hold = 1'b0;
  logic [DW-1:0] plog [0:15];
  assign per_ready = !rdy_hold && ((cyc % 3) != 2);
  assign per_rdata = 32'hA500_0000 + DW'(per_cnt);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (per_ack) begin
      plog[per_cnt % 16] <= per_wdata;
      per_cnt <= per_cnt + 1;
    end
  end

  // count rising edges of the bus request
  logic req_d = 1'b0;
  int req_rises = 0;
  always @(posedge clk) begin
    req_d <= bus_req;
    if (bus_req && !req_d) req_rises <= req_rises + 1;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
  endtask

  task automatic run(input int dir, input int steal, input int size, input int n);
    int step, src, dst, p0, r0, a;
    bit seen;
    logic [31:0] v;
    step = 1 << size; src = 'h10; dst = 'h80;
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 | i;
    p0 = per_cnt;
    reg_write(3'd0, src);
    reg_write(3'd1, dst);
    reg_write(3'd2, n);
    r0 = req_rises;
    reg_write(3'd3, 1 | (steal << 1) | (dir << 2) | (size << 4) | (1 << 6));
    wait_irq(seen);
    chk("R10 irq at completion", {31'b0, seen}, 32'd1);
    for (int i = 0; i < n; i++) begin
      a = src + i * step;
      if (dir == 0)
        chk("R3 peripheral data in memory", mem[a], 32'hA500_0000 + p0 + i);
      else if (dir == 1)
        chk("R4 memory data to peripheral", plog[(p0 + i) % 16], 32'h5A00_0000 | a);
      else
        chk("R5 copied word", mem[dst + i * step], 32'h5A00_0000 | a);
    end
    reg_read(3'd0, v); chk("R6 primary pointer", v, src + n * step);
    reg_read(3'd1, v); chk("R6 secondary pointer", v, (dir >= 2) ? dst + n * step : dst);
    reg_read(3'd2, v); chk("R7 remaining count", v, 0);
    chk(steal ? "R9 requests per block" : "R8 requests per block",
        req_rises - r0, steal ? n : 1);
    reg_read(3'd4, v); chk("R10 status done not busy", v, 2);
    reg_write(3'd4, 2);
    reg_read(3'd4, v); chk("R10 done cleared by W1C", v, 0);
    chk("R10 irq low after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit seen;
    int r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      reg_read(r[2:0], v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 bus_req after reset", {31'b0, bus_req}, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);

    // sweep: direction x policy x unit size x length
    for (int d = 0; d < 3; d++)
      for (int s = 0; s < 2; s++)
        for (int z = 0; z < 4; z++)
          for (int n = 1; n <= 3; n += 2)
            run(d, s, z, n);
    run(3, 1, 1, 2); // code 3 also copies memory (R5)

    // R12 zero count
    reg_write(3'd2, 0);
    r0 = req_rises;
    reg_write(3'd3, 1 | (1 << 6));
    reg_read(3'd4, v); chk("R12 zero count done at once", v, 2);
    chk("R12 zero count irq", {31'b0, irq}, 1);
    repeat (5) @(negedge clk);
    chk("R12 zero count no request", req_rises - r0, 0);
    reg_write(3'd4, 2);

    // R11 writes while busy are ignored
    rdy_hold = 1'b1;
    reg_write(3'd0, 'h40);
    reg_write(3'd2, 2);
    r0 = req_rises;
    reg_write(3'd3, 1 | (1 << 6));
    repeat (5) @(negedge clk);
    reg_read(3'd4, v); chk("R11 busy while stalled", v, 1);
    reg_read(3'd2, v); chk("R7 remaining before any unit", v, 2);
    reg_write(3'd2, 7);
    reg_write(3'd0, 'h99);
    reg_write(3'd3, 1 | (1 << 1) | (2 << 2) | (1 << 6));
    reg_read(3'd2, v); chk("R11 count write ignored", v, 2);
    reg_read(3'd0, v); chk("R11 pointer write ignored", v, 'h40);
    reg_read(3'd3, v); chk("R11 control write ignored", v, 32'h40);
    rdy_hold = 1'b0;
    wait_irq(seen);
    chk("R11 original block completes", {31'b0, seen}, 1);
    reg_read(3'd0, v); chk("R11 pointer after block", v, 'h42);
    chk("R11 block policy kept", req_rises - r0, 1);
    reg_write(3'd4, 2);

    // R10 interrupt masked when enable clear
    reg_write(3'd2, 1);
    reg_write(3'd3, 1);
    for (int k = 0; k < 50; k++) begin
      reg_read(3'd4, v);
      if (v == 2) break;
    end
    chk("R10 done with irq disabled", v, 2);
    chk("R10 irq masked", {31'b0, irq}, 0);
    reg_write(3'd4, 2);
    reg_read(3'd4, v); chk("R10 cleared", v, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule